// File: doc/BRIEF.md
# PCI 64-bit memory write master sequencer

This block is the bus-master state machine that turns a local write request into a 64-bit PCI memory write burst. A request carries a start address and a number of 64-bit data phases. The data words and their byte enables arrive on a separate valid/ready stream. The block drives the frame, 64-bit request, initiator-ready, AD and C/BE signals. It watches the target's device-select, 64-bit acknowledge, target-ready and stop signals. When the transaction ends, it returns a one-cycle completion report to the local side. The report gives an outcome code and the number of data phases that completed, so the local side can reissue any remainder itself.

A static mode input selects one of two handshakes.

- **Cautious mode (mode low).** This is safe when the target width is unknown. Initiator-ready is held off until the target has claimed the cycle. A single-phase 64-bit write is refused, because a 32-bit target would drop its upper half.
- **Assumed-64-bit mode (mode high).** Every target is taken to be 64-bit. Initiator-ready is asserted in the first cycle after the address phase, and single-phase writes are issued.

The mode may change only while the block is idle.

**Request interface.** A request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle.

**Data stream and back-pressure.**

- `wr_ready` is the data-accepted strobe. It is high exactly in a cycle where a data phase completes on the bus.
- The word on `wr_data`/`wr_be` is consumed at that edge. The source then presents the next word in the following cycle.
- The first initiator-ready assertion waits for `wr_valid`.
- Once a burst has started, the source must keep `wr_valid` high with the current word stable until the burst ends. Initiator-ready is never withdrawn while a phase is in progress.

Top module: `pci_wr64_master`

## Requirements
- R1: While and after reset, and with no request, `framen_o`, `req64n_o` and `irdyn_o` are high, `cmd_ready` is high, and `done_valid` and `wr_ready` are low.
- R2: Cycle numbering for R2 to R12:
  - The cycle after an accepted request is the address cycle, cycle 0.
  - In cycle 0, `framen_o` and `req64n_o` are low.
  - In cycle 0, `ad_o` carries the address zero-extended to 64 bits and `cbe_o` is 8'h07 (memory-write command 4'b0111 on the low nibble, zero on the high nibble).
- R3: In cautious mode, `irdyn_o` stays high until `devseln_i` has been sampled low. It goes low in the cycle after the first clock edge where `devseln_i` is sampled low, provided `wr_valid` is high.
- R4: In assumed-64-bit mode, `irdyn_o` goes low in cycle 1 regardless of `devseln_i`, provided `wr_valid` is high. This is a shorter address-to-ready latency than cautious mode for any claim delay.
- R5: Some requests are refused:
  - A request of zero data phases, in either mode.
  - A request of exactly one data phase, in cautious mode.
  - A refused request produces no bus activity. It gives a `done_valid` pulse in the cycle after acceptance, with `done_status`=4 and `done_count`=0.
- R6: In assumed-64-bit mode, a one-phase write raises `framen_o` and `req64n_o` in cycle 1, the same cycle that `irdyn_o` first goes low.
- R7: A data phase completes in a cycle where `irdyn_o` and `trdyn_i` are both low. `wr_ready` is high in exactly those cycles. During each data cycle `ad_o` equals `wr_data` and `cbe_o` equals the bitwise inverse of `wr_be` (`wr_be` is active high).
- R8: `framen_o` and `req64n_o` rise together, in the cycle where `irdyn_o` is driven for the last data phase. After the last phase completes, `irdyn_o` is high in the next cycle, and `done_valid` pulses in that cycle with `done_status`=0 and `done_count` equal to the requested count.
- R9: Master abort:
  - Trigger: `devseln_i` has not been sampled low at the end of any of cycles 1 to 5.
  - Cycle 6: `framen_o` is high and `irdyn_o` is low.
  - Cycle 7: both are released, and `done_valid` pulses with `done_status`=2 and `done_count`=0.
- R10: Disconnect (`stopn_i` sampled low with `devseln_i` low in cycle s, before the last phase):
  - A phase that also completes in cycle s is counted.
  - Cycle s+1: `framen_o` is high and `irdyn_o` is low.
  - Cycle s+2: `done_valid` pulses with `done_status`=1 and `done_count` equal to the completed phases.
- R11: Target abort (`stopn_i` sampled low with `devseln_i` high in cycle s, after a claim) ends like R10, with `done_status`=3.
- R12: Once `irdyn_o` is low in a data phase, it stays low through target wait states (`trdyn_i` high) until the phase completes or the transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_assume64 | input | 1 | 1: assume every target is 64-bit; 0: cautious mode |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request accepted this cycle when high with cmd_valid (idle) |
| cmd_addr | input | ADDR_W | Start address |
| cmd_count | input | CNT_W | Number of 64-bit data phases |
| wr_valid | input | 1 | Data word valid |
| wr_ready | output | 1 | Data phase completed; current word consumed |
| wr_data | input | BUS_W | Data word |
| wr_be | input | BUS_W/8 | Active-high byte enables for the word |
| done_valid | output | 1 | One-cycle completion report |
| done_status | output | 3 | 0 done, 1 disconnect, 2 master abort, 3 target abort, 4 refused |
| done_count | output | CNT_W | Completed data phases |
| framen_o | output | 1 | Frame, active low |
| req64n_o | output | 1 | 64-bit request, active low |
| irdyn_o | output | 1 | Initiator ready, active low |
| ad_o | output | BUS_W | Address/data bus |
| cbe_o | output | BUS_W/8 | Command / byte enables, active low on data |
| devseln_i | input | 1 | Target claim, active low |
| ack64n_i | input | 1 | Target 64-bit acknowledge, active low |
| trdyn_i | input | 1 | Target ready, active low |
| stopn_i | input | 1 | Target stop, active low |

## Verification
Some rules are checked by assertions on every cycle:

- In cautious mode, initiator-ready never falls before a claim.
- Frame only rises while initiator-ready is low.
- Initiator-ready is held through target wait states.
- A missing claim always ends the data state at the deadline.
- The phase counter never underflows.
- No cautious-mode burst reports a successful single phase.

Other behaviour only the bench scenarios can show:

- The exact cycles of each waveform for a range of claim delays and wait states.
- The data and byte enables on each completed phase.
- The counts reported after disconnect and abort.
- That the assumed-64-bit mode actually shortens the address-to-ready latency.

// File: rtl/pci_wr64_pkg.sv
package pci_wr64_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_DATA = 2'd2,
    S_END  = 2'd3
  } wr_state_e;

  localparam logic [2:0] RES_OK     = 3'd0;
  localparam logic [2:0] RES_DISC   = 3'd1;
  localparam logic [2:0] RES_MABORT = 3'd2;
  localparam logic [2:0] RES_TABORT = 3'd3;
  localparam logic [2:0] RES_REFUSE = 3'd4;

  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

endpackage

// File: rtl/pci_wr64_claim_timer.sv
// Tracks whether the target has claimed the cycle, and raises the
// master-abort deadline when no claim arrives in time.
module pci_wr64_claim_timer #(
  parameter int TMO = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,    // address cycle
  input  logic active_i,   // data state
  input  logic devseln_i,
  output logic claimed_o,
  output logic timeout_o
);
  localparam int TW = $clog2(TMO + 1);

  logic [TW-1:0] cnt_q;
  logic          claimed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      claimed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q     <= TW'(1);
      claimed_q <= 1'b0;
    end else if (active_i) begin
      if (cnt_q != TW'(TMO)) cnt_q <= cnt_q + TW'(1);
      if (!devseln_i) claimed_q <= 1'b1;
    end
  end

  assign claimed_o = claimed_q;
  assign timeout_o = active_i & devseln_i & ~claimed_q & (cnt_q == TW'(TMO));

  // R9: a missed claim deadline always leaves the data state
  p_mabort_deadline_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && timeout_o) |=> !active_i);

endmodule

// File: rtl/pci_wr64_phase_ctr.sv
// Remaining and completed data-phase bookkeeping for one burst.
module pci_wr64_phase_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             rem_one_o,
  output logic [CNT_W-1:0] rem_after_o,
  output logic [CNT_W-1:0] done_cnt_o
);
  logic [CNT_W-1:0] total_q, rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      rem_q   <= '0;
    end else if (load_i) begin
      total_q <= count_i;
      rem_q   <= count_i;
    end else if (dec_i) begin
      rem_q   <= rem_q - CNT_W'(1);
    end
  end

  assign rem_one_o   = (rem_q == CNT_W'(1));
  assign rem_after_o = rem_q - CNT_W'(dec_i);
  assign done_cnt_o  = total_q - rem_after_o;

  // R8: no phase completes once the burst's count is used up
  p_rem_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (rem_q != '0));

endmodule

// File: rtl/pci_wr64_bus_mux.sv
// Selects address or data onto AD and C/BE and detects phase completion.
module pci_wr64_bus_mux
  import pci_wr64_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64
) (
  input  logic               addr_phase_i,
  input  logic               data_phase_i,
  input  logic               beat_i,
  input  logic               irdyn_q_i,
  input  logic               trdyn_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BUS_W-1:0]   wr_data_i,
  input  logic [BUS_W/8-1:0] wr_be_i,
  output logic [BUS_W-1:0]   ad_o,
  output logic [BUS_W/8-1:0] cbe_o,
  output logic               complete_o
);
  localparam int BE_W = BUS_W / 8;

  always_comb begin
    ad_o  = '0;
    cbe_o = '0;
    if (addr_phase_i) begin
      ad_o  = BUS_W'(addr_i);
      cbe_o = BE_W'(CMD_MEM_WRITE);
    end else if (data_phase_i) begin
      ad_o  = wr_data_i;
      cbe_o = ~wr_be_i;
    end
  end

  assign complete_o = beat_i & ~irdyn_q_i & ~trdyn_i;

endmodule

// File: rtl/pci_wr64_master.sv
module pci_wr64_master
  import pci_wr64_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 8,
  parameter int BUS_W      = 64,
  parameter int DEVSEL_TMO = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_assume64,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [CNT_W-1:0]   cmd_count,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic [BUS_W/8-1:0] wr_be,
  output logic               done_valid,
  output logic [2:0]         done_status,
  output logic [CNT_W-1:0]   done_count,
  output logic               framen_o,
  output logic               req64n_o,
  output logic               irdyn_o,
  output logic [BUS_W-1:0]   ad_o,
  output logic [BUS_W/8-1:0] cbe_o,
  input  logic               devseln_i,
  input  logic               ack64n_i,
  input  logic               trdyn_i,
  input  logic               stopn_i
);
  wr_state_e        st_q, st_d;
  logic             frame_q, frame_d, req64_q, irdy_q, irdy_d;
  logic             done_q, done_d;
  logic [2:0]       stat_q, stat_d, endst_q, endst_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic [ADDR_W-1:0] addr_q;

  logic             accept, refuse, load;
  logic             claimed, timeout, complete, may_irdy;
  logic             rem_one;
  logic [CNT_W-1:0] rem_after, done_cnt;

  assign cmd_ready = (st_q == S_IDLE);
  assign accept    = cmd_valid & cmd_ready;
  assign refuse    = accept & ((cmd_count == '0) |
                     (!mode_assume64 && cmd_count == CNT_W'(1)));
  assign load      = accept & ~refuse;
  assign may_irdy  = mode_assume64 | ~devseln_i | claimed;

  pci_wr64_claim_timer #(.TMO(DEVSEL_TMO)) u_claim (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (st_q == S_ADDR),
    .active_i  (st_q == S_DATA),
    .devseln_i (devseln_i),
    .claimed_o (claimed),
    .timeout_o (timeout)
  );

  pci_wr64_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .count_i     (cmd_count),
    .dec_i       (complete),
    .rem_one_o   (rem_one),
    .rem_after_o (rem_after),
    .done_cnt_o  (done_cnt)
  );

  pci_wr64_bus_mux #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_mux (
    .addr_phase_i (st_q == S_ADDR),
    .data_phase_i ((st_q == S_DATA) || (st_q == S_END)),
    .beat_i       (st_q == S_DATA),
    .irdyn_q_i    (irdy_q),
    .trdyn_i      (trdyn_i),
    .addr_i       (addr_q),
    .wr_data_i    (wr_data),
    .wr_be_i      (wr_be),
    .ad_o         (ad_o),
    .cbe_o        (cbe_o),
    .complete_o   (complete)
  );

  always_comb begin
    st_d    = st_q;
    frame_d = frame_q;
    irdy_d  = irdy_q;
    done_d  = 1'b0;
    stat_d  = stat_q;
    dcnt_d  = dcnt_q;
    endst_d = endst_q;
    unique case (st_q)
      S_IDLE: begin
        if (refuse) begin
          done_d = 1'b1;
          stat_d = RES_REFUSE;
          dcnt_d = '0;
        end else if (accept) begin
          st_d    = S_ADDR;
          frame_d = 1'b0;
        end
      end
      S_ADDR: begin
        st_d = S_DATA;
        if (mode_assume64 && wr_valid) begin
          irdy_d = 1'b0;
          if (rem_one) frame_d = 1'b1;
        end
      end
      S_DATA: begin
        if (complete && rem_after == '0) begin
          st_d    = S_IDLE;
          irdy_d  = 1'b1;
          frame_d = 1'b1;
          done_d  = 1'b1;
          stat_d  = RES_OK;
          dcnt_d  = done_cnt;
        end else if (!stopn_i || timeout) begin
          st_d    = S_END;
          frame_d = 1'b1;
          irdy_d  = 1'b0;
          endst_d = !stopn_i ? (devseln_i ? RES_TABORT : RES_DISC) : RES_MABORT;
        end else if (complete) begin
          if (rem_after == CNT_W'(1)) frame_d = 1'b1;
        end else if (irdy_q && may_irdy && wr_valid) begin
          irdy_d = 1'b0;
          if (rem_one) frame_d = 1'b1;
        end
      end
      S_END: begin
        st_d    = S_IDLE;
        irdy_d  = 1'b1;
        frame_d = 1'b1;
        done_d  = 1'b1;
        stat_d  = endst_q;
        dcnt_d  = done_cnt;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      frame_q <= 1'b1;
      req64_q <= 1'b1;
      irdy_q  <= 1'b1;
      done_q  <= 1'b0;
      stat_q  <= RES_OK;
      dcnt_q  <= '0;
      endst_q <= RES_OK;
      addr_q  <= '0;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_d;
      req64_q <= frame_d;
      irdy_q  <= irdy_d;
      done_q  <= done_d;
      stat_q  <= stat_d;
      dcnt_q  <= dcnt_d;
      endst_q <= endst_d;
      if (accept) addr_q <= cmd_addr;
    end
  end

  assign framen_o    = frame_q;
  assign req64n_o    = req64_q;
  assign irdyn_o     = irdy_q;
  assign wr_ready    = complete;
  assign done_valid  = done_q;
  assign done_status = stat_q;
  assign done_count  = dcnt_q;

  // R3: in cautious mode irdyn only falls after the target has claimed
  p_irdy_waits_devsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_assume64 && $fell(irdy_q) && st_q != S_END) |-> claimed);

  // R8: frame is released only while initiator-ready is driven
  p_frame_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_q) |-> !irdy_q);

  // R12: committed initiator-ready is held through target wait states
  p_irdy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DATA && !irdy_q && trdyn_i && stopn_i && !timeout) |=> !irdy_q);

  // R5: cautious mode never reports a successful single-phase burst
  p_no_single_cautious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !mode_assume64 && stat_q == RES_OK) |-> (dcnt_q != CNT_W'(1)));

  // R4: the assumed-64-bit mode relies on every claim carrying ack64n
  p_target_is_64_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_assume64 && !devseln_i) |-> !ack64n_i);

endmodule

// File: tb/test_pci_wr64_master.sv
module test_pci_wr64_master;
  localparam int CNT_W = 8;
  localparam int TMO   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_assume64 = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic        wr_valid = 1'b1;
  logic        wr_ready;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_be = '0;
  logic        done_valid;
  logic [2:0]  done_status;
  logic [CNT_W-1:0] done_count;
  logic        framen_o, req64n_o, irdyn_o;
  logic [63:0] ad_o;
  logic [7:0]  cbe_o;
  logic        devseln_i = 1'b1, ack64n_i = 1'b1, trdyn_i = 1'b1, stopn_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pci_wr64_master #(.CNT_W(CNT_W), .DEVSEL_TMO(TMO)) i_pci_wr64_master (
    .clk(clk), .rst_n(rst_n), .mode_assume64(mode_assume64),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_be(wr_be), .done_valid(done_valid),
    .done_status(done_status), .done_count(done_count),
    .framen_o(framen_o), .req64n_o(req64n_o), .irdyn_o(irdyn_o),
    .ad_o(ad_o), .cbe_o(cbe_o), .devseln_i(devseln_i), .ack64n_i(ack64n_i),
    .trdyn_i(trdyn_i), .stopn_i(stopn_i)
  );

  function automatic logic [63:0] word(int k);
    return {32'hC0DE_0000 + 32'(k), 32'h5A00_0000 + 32'(k * 3)};
  endfunction

  function automatic logic [7:0] bytes(int k);
    return 8'hFF ^ 8'(k << 1);
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Runs one burst; expectations come from the cycle numbering in the requirements.
  task automatic run_case(input string tag, input bit mode, input int n, input int d,
                          input int w, input int stop_t, input bit tabort,
                          input bit noclaim, output int first_irdy);
    int f, e, c0, last, fr_end, il_lo, il_hi, r0, r1, dn, ecnt, idx;
    logic [2:0]  est;
    logic [4:0]  act, exp;
    logic [31:0] addr;
    f = mode ? 1 : (noclaim ? 1000 : d + 1);
    r0 = 1000; r1 = -1;
    if (noclaim) begin
      e = TMO + 1; fr_end = e - 1; il_lo = mode ? 1 : e; il_hi = e;
      dn = e + 1; est = 3'd2; ecnt = 0;
    end else if (tabort) begin
      e = stop_t + 1; fr_end = e - 1; il_lo = f; il_hi = e;
      dn = e + 1; est = 3'd3; ecnt = 0;
    end else if (stop_t >= 0) begin
      c0 = (f > d + w) ? f : d + w;
      e = stop_t + 1; fr_end = e - 1; il_lo = f; il_hi = e;
      r0 = c0; r1 = stop_t; dn = e + 1; est = 3'd1; ecnt = stop_t - c0 + 1;
    end else begin
      c0 = (f > d + w) ? f : d + w;
      last = c0 + n - 1;
      fr_end = (n == 1) ? f - 1 : last - 1;
      il_lo = f; il_hi = last; r0 = c0; r1 = last;
      dn = last + 1; est = 3'd0; ecnt = n;
    end
    addr = 32'h1000_0000 + 32'(n * 16 + d);
    mode_assume64 = mode;
    cmd_valid = 1'b1; cmd_addr = addr; cmd_count = CNT_W'(n);
    idx = 0; wr_data = word(0); wr_be = bytes(0);
    @(negedge clk);
    chk(cmd_ready == 1'b1, {tag, " R2 request taken when idle"}, 64'(cmd_ready), 64'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    first_irdy = -1;
    for (int t = 0; t <= dn + 1; t++) begin
      devseln_i = !(!noclaim && t >= d && t < dn && !(tabort && t >= stop_t));
      trdyn_i   = !(!noclaim && !tabort && t >= d + w && t < dn &&
                    (stop_t < 0 || t <= stop_t));
      stopn_i   = !(stop_t >= 0 && t >= stop_t && t < dn);
      ack64n_i  = devseln_i;
      wr_data   = word(idx);
      wr_be     = bytes(idx);
      @(negedge clk);
      exp[4] = !(t <= fr_end);
      exp[3] = !(t <= fr_end);
      exp[2] = !(t >= il_lo && t <= il_hi);
      exp[1] = (t >= r0 && t <= r1);
      exp[0] = (t == dn);
      act = {framen_o, req64n_o, irdyn_o, wr_ready, done_valid};
      chk(act == exp, $sformatf("%s cycle %0d frame/req64/irdy/ready/done", tag, t),
          64'(act), 64'(exp));
      if (t == 0)
        chk(ad_o == {32'h0, addr} && cbe_o == 8'h07, {tag, " R2 address phase"},
            ad_o ^ 64'(cbe_o), {32'h0, addr} ^ 64'h07);
      if (!irdyn_o && first_irdy < 0) first_irdy = t;
      if (wr_ready) begin
        chk(ad_o == word(idx) && cbe_o == ~bytes(idx), {tag, " R7 data word and byte enables"},
            ad_o ^ 64'(cbe_o), word(idx) ^ 64'(~bytes(idx)));
        idx++;
      end
      if (t == dn)
        chk(done_status == est && done_count == CNT_W'(ecnt),
            {tag, " R8 R9 R10 R11 completion report"},
            64'({done_status, done_count}), 64'({est, CNT_W'(ecnt)}));
      @(posedge clk); #1;
    end
    devseln_i = 1'b1; trdyn_i = 1'b1; stopn_i = 1'b1; ack64n_i = 1'b1;
  endtask

  task automatic refuse_case(input string tag, input bit mode, input int n);
    logic [4:0] act;
    mode_assume64 = mode;
    cmd_valid = 1'b1; cmd_addr = 32'h2000_0040; cmd_count = CNT_W'(n);
    @(negedge clk);
    chk(cmd_ready == 1'b1, {tag, " R5 request taken"}, 64'(cmd_ready), 64'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    act = {framen_o, irdyn_o, done_valid, done_status == 3'd4, done_count == '0};
    chk(act == 5'b11111, {tag, " R5 refused: no bus activity, status 4 count 0"},
        64'({framen_o, irdyn_o, done_valid, done_status, done_count}), 64'h0);
    @(posedge clk); #1;
    @(negedge clk);
    act = {framen_o, req64n_o, irdyn_o, done_valid, cmd_ready};
    chk(act == 5'b11101, {tag, " R5 bus stays idle after refusal"}, 64'(act), 64'b11101);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat_dflt, lat_asm, dummy;
    repeat (3) @(negedge clk);
    chk({framen_o, req64n_o, irdyn_o, cmd_ready, done_valid, wr_ready} == 6'b111100,
        "R1 outputs in reset", 64'({framen_o, req64n_o, irdyn_o, cmd_ready, done_valid, wr_ready}),
        64'b111100);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({framen_o, req64n_o, irdyn_o, cmd_ready, done_valid, wr_ready} == 6'b111100,
        "R1 outputs idle after reset", 64'({framen_o, req64n_o, irdyn_o, cmd_ready, done_valid, wr_ready}),
        64'b111100);
    @(posedge clk); #1;

    run_case("cautious n4 d1 R3 R8", 1'b0, 4, 1, 0, -1, 1'b0, 1'b0, lat_dflt);
    run_case("cautious n3 d3 w2 R3 R12", 1'b0, 3, 3, 2, -1, 1'b0, 1'b0, dummy);
    run_case("assume n4 d2 R4 R7", 1'b1, 4, 2, 0, -1, 1'b0, 1'b0, lat_asm);
    chk(lat_asm < lat_dflt, "R4 assumed mode has shorter irdy latency",
        64'(lat_asm), 64'(lat_dflt));
    run_case("assume n1 d3 R6", 1'b1, 1, 3, 0, -1, 1'b0, 1'b0, dummy);
    run_case("assume n3 d1 w1 R12", 1'b1, 3, 1, 1, -1, 1'b0, 1'b0, dummy);
    refuse_case("cautious n1", 1'b0, 1);
    refuse_case("assume n0", 1'b1, 0);
    run_case("cautious n2 noclaim R9", 1'b0, 2, 1, 0, -1, 1'b0, 1'b1, dummy);
    run_case("assume n3 noclaim R9", 1'b1, 3, 1, 0, -1, 1'b0, 1'b1, dummy);
    run_case("cautious n4 stop R10", 1'b0, 4, 1, 0, 3, 1'b0, 1'b0, dummy);
    run_case("assume n2 abort R11", 1'b1, 2, 1, 99, 2, 1'b1, 1'b0, dummy);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule